// File: doc/BRIEF.md
# Fast Context Shadow Register

This block keeps a single saved copy of three core registers: an 8-bit status register, an 8-bit working accumulator and a 4-bit bank-select register. The copy lets an interrupt handler or a short subroutine return without saving those registers in software. The core's control unit sends event strobes: an interrupt-vector strobe, a call strobe with a "fast" qualifier, and two return strobes (subroutine return and interrupt return) that share one "fast" qualifier. The block captures the live register values on a save event. On a fast return it presents the saved values with a one-cycle valid strobe, and the core multiplexes them back into its registers.

The store is a single entry, not a stack. It has no pointer, and each save simply replaces the previous contents. Software cannot read or write it. A parameter chooses whether the restore outputs are registered (one cycle after the return strobe) or driven combinationally in the same cycle. The default is registered.

Top module: `ctx_shadow_unit`

## Requirements
- R1: After reset the shadow store holds zero in all three fields and `rst_valid_o` is low. A fast return issued before any save restores all-zero values.
- R2: An interrupt-vector strobe (`irq_vec_i`) loads the live status, working register and bank-select values into the store, whatever the interrupt's priority.
- R3: A call strobe saves the live values only when `call_fast_i` is high in the same cycle. A call without the fast qualifier leaves the store unchanged.
- R4: A return strobe (`ret_i` or `reti_i`) with `ret_fast_i` high is a fast return. With the default registered outputs, `rst_valid_o` is high in the next cycle and the restore outputs carry the store contents as they were in the cycle of the return.
- R5: A return strobe with `ret_fast_i` low produces no valid pulse and leaves the store unchanged.
- R6: A second save before any restore overwrites the first. A later fast return gives only the most recent values.
- R7: When a save and a fast return occur in the same cycle, the restore delivers the old store contents, and the new live values are stored for the next restore.
- R8: `rst_valid_o` is high for exactly one cycle per cycle that carries a fast return. Fast returns in consecutive cycles give consecutive pulses. `ret_i` and `reti_i` together in one cycle give a single pulse.
- R9: While `rst_valid_o` is low, the three restore outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_stat_i | input | 8 | Current status register value |
| live_wreg_i | input | 8 | Current working register value |
| live_bank_i | input | 4 | Current bank-select value |
| irq_vec_i | input | 1 | Core is vectoring to an interrupt (save) |
| call_i | input | 1 | Subroutine call executed |
| call_fast_i | input | 1 | Qualifies `call_i` as a fast call |
| ret_i | input | 1 | Subroutine return executed |
| reti_i | input | 1 | Return from interrupt executed |
| ret_fast_i | input | 1 | Qualifies either return as fast |
| rst_stat_o | output | 8 | Restored status value |
| rst_wreg_o | output | 8 | Restored working register value |
| rst_bank_o | output | 4 | Restored bank-select value |
| rst_valid_o | output | 1 | Restore strobe, one cycle per fast return |

## Verification
The hardest case to reach from the ports is a save and a fast return in the same cycle, particularly when it comes right after another save with different live values. Only that ordering shows whether the restore path reads the store before or after it is overwritten. Directed sequences first load a known pattern and then issue an interrupt-vector strobe together with a fast interrupt return while the live values differ. A second fast return then confirms that the new values were kept. A long randomized phase follows with dense save and return strobes and a cycle-by-cycle behavioural model. It produces back-to-back fast returns, overwrites during pending restores and unqualified calls and returns in all combinations.

// File: rtl/ctx_shadow_pkg.sv
package ctx_shadow_pkg;

   localparam int unsigned STAT_W_DEF = 8;
   localparam int unsigned WREG_W_DEF = 8;
   localparam int unsigned BANK_W_DEF = 4;
   localparam int unsigned NUM_FIELDS = 3;

   // Operation requested of the shadow store in one cycle
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_SAVE = 2'b01,
      OP_REST = 2'b10,
      OP_SWAP = 2'b11
   } ctx_op_e;

   function automatic logic op_saves(ctx_op_e op);
      return (op == OP_SAVE) || (op == OP_SWAP);
   endfunction

   function automatic logic op_restores(ctx_op_e op);
      return (op == OP_REST) || (op == OP_SWAP);
   endfunction

endpackage

// File: rtl/ctx_shadow_decode.sv
module ctx_shadow_decode
   import ctx_shadow_pkg::*;
(
   input  logic    irq_vec_i,
   input  logic    call_i,
   input  logic    call_fast_i,
   input  logic    ret_i,
   input  logic    reti_i,
   input  logic    ret_fast_i,
   output ctx_op_e op_o
);

   logic save_req;
   logic rest_req;

   always_comb begin
      save_req = irq_vec_i | (call_i & call_fast_i);
      rest_req = (ret_i | reti_i) & ret_fast_i;
      unique case ({rest_req, save_req})
         2'b01:   op_o = OP_SAVE;
         2'b10:   op_o = OP_REST;
         2'b11:   op_o = OP_SWAP;
         default: op_o = OP_IDLE;
      endcase
   end

endmodule

// File: rtl/ctx_shadow_slot.sv
module ctx_shadow_slot #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_width
      $error("ctx_shadow_slot: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (load_i)
         q_o <= d_i;
   end

endmodule

// File: rtl/ctx_shadow_out.sv
module ctx_shadow_out #(
   parameter int unsigned W       = 20,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire_i,
   input  logic [W-1:0] store_i,
   output logic [W-1:0] data_o,
   output logic         valid_o
);

   if (OUT_REG) begin : g_registered
      logic [W-1:0] data_q;
      logic         valid_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
         end else begin
            valid_q <= fire_i;
            data_q  <= fire_i ? store_i : '0;
         end
      end

      assign data_o  = data_q;
      assign valid_o = valid_q;
   end else begin : g_direct
      assign data_o  = fire_i ? store_i : '0;
      assign valid_o = fire_i;
   end

endmodule

// File: rtl/ctx_shadow_unit.sv
module ctx_shadow_unit
   import ctx_shadow_pkg::*;
#(
   parameter int unsigned STAT_W  = STAT_W_DEF,
   parameter int unsigned WREG_W  = WREG_W_DEF,
   parameter int unsigned BANK_W  = BANK_W_DEF,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] live_stat_i,
   input  logic [WREG_W-1:0] live_wreg_i,
   input  logic [BANK_W-1:0] live_bank_i,
   input  logic              irq_vec_i,
   input  logic              call_i,
   input  logic              call_fast_i,
   input  logic              ret_i,
   input  logic              reti_i,
   input  logic              ret_fast_i,
   output logic [STAT_W-1:0] rst_stat_o,
   output logic [WREG_W-1:0] rst_wreg_o,
   output logic [BANK_W-1:0] rst_bank_o,
   output logic              rst_valid_o
);

   localparam int unsigned TOT_W = STAT_W + WREG_W + BANK_W;
   localparam int unsigned FW [NUM_FIELDS] = '{STAT_W, WREG_W, BANK_W};
   localparam int unsigned FO [NUM_FIELDS] = '{0, STAT_W, STAT_W + WREG_W};

   if (STAT_W < 1 || WREG_W < 1 || BANK_W < 1) begin : g_bad_fields
      $error("ctx_shadow_unit: every field width must be at least 1");
   end

   ctx_op_e          op;
   logic             do_save;
   logic             do_rest;
   logic [TOT_W-1:0] live_vec;
   logic [TOT_W-1:0] store_vec;
   logic [TOT_W-1:0] out_vec;

   ctx_shadow_decode u_decode (
      .irq_vec_i  (irq_vec_i),
      .call_i     (call_i),
      .call_fast_i(call_fast_i),
      .ret_i      (ret_i),
      .reti_i     (reti_i),
      .ret_fast_i (ret_fast_i),
      .op_o       (op)
   );

   assign do_save  = op_saves(op);
   assign do_rest  = op_restores(op);
   assign live_vec = {live_bank_i, live_wreg_i, live_stat_i};

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      ctx_shadow_slot #(.W(FW[i])) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .load_i(do_save),
         .d_i   (live_vec[FO[i] +: FW[i]]),
         .q_o   (store_vec[FO[i] +: FW[i]])
      );
   end

   ctx_shadow_out #(.W(TOT_W), .OUT_REG(OUT_REG)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (do_rest),
      .store_i(store_vec),
      .data_o (out_vec),
      .valid_o(rst_valid_o)
   );

   assign rst_stat_o = out_vec[FO[0] +: STAT_W];
   assign rst_wreg_o = out_vec[FO[1] +: WREG_W];
   assign rst_bank_o = out_vec[FO[2] +: BANK_W];

endmodule

// File: rtl/ctx_shadow_chk.sv
module ctx_shadow_chk #(
   parameter int unsigned STAT_W  = 8,
   parameter int unsigned WREG_W  = 8,
   parameter int unsigned BANK_W  = 4,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [STAT_W-1:0] live_stat_i,
   input logic [WREG_W-1:0] live_wreg_i,
   input logic [BANK_W-1:0] live_bank_i,
   input logic              irq_vec_i,
   input logic              call_i,
   input logic              call_fast_i,
   input logic              ret_i,
   input logic              reti_i,
   input logic              ret_fast_i,
   input logic [STAT_W-1:0] rst_stat_o,
   input logic [WREG_W-1:0] rst_wreg_o,
   input logic [BANK_W-1:0] rst_bank_o,
   input logic              rst_valid_o
);

   localparam int unsigned TOT_W = STAT_W + WREG_W + BANK_W;

   logic             saw_save;
   logic             saw_fast_ret;
   logic [TOT_W-1:0] mirror;
   logic [TOT_W-1:0] outs;

   assign saw_save     = irq_vec_i || (call_i && call_fast_i);
   assign saw_fast_ret = (ret_i || reti_i) && ret_fast_i;
   assign outs         = {rst_bank_o, rst_wreg_o, rst_stat_o};

   // independent record of what the store ought to hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mirror <= '0;
      else if (saw_save)
         mirror <= {live_bank_i, live_wreg_i, live_stat_i};
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!rst_valid_o && outs == '0));

   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_valid_o |-> (outs == '0));

   if (OUT_REG) begin : g_reg_chk
      assert_fast_ret_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
         saw_fast_ret |=> rst_valid_o);

      assert_slow_ret_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !saw_fast_ret |=> !rst_valid_o);

      assert_old_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
         rst_valid_o |-> (outs == $past(mirror)));
   end else begin : g_dir_chk
      assert_fast_ret_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
         saw_fast_ret |-> rst_valid_o);

      assert_slow_ret_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !saw_fast_ret |-> !rst_valid_o);

      assert_old_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
         rst_valid_o |-> (outs == mirror));
   end

endmodule

bind ctx_shadow_unit ctx_shadow_chk #(
   .STAT_W (STAT_W),
   .WREG_W (WREG_W),
   .BANK_W (BANK_W),
   .OUT_REG(OUT_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .live_stat_i(live_stat_i),
   .live_wreg_i(live_wreg_i),
   .live_bank_i(live_bank_i),
   .irq_vec_i  (irq_vec_i),
   .call_i     (call_i),
   .call_fast_i(call_fast_i),
   .ret_i      (ret_i),
   .reti_i     (reti_i),
   .ret_fast_i (ret_fast_i),
   .rst_stat_o (rst_stat_o),
   .rst_wreg_o (rst_wreg_o),
   .rst_bank_o (rst_bank_o),
   .rst_valid_o(rst_valid_o)
);

// File: tb/ctx_shadow_unit_test.sv
`timescale 1ns/1ps
module ctx_shadow_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] live_stat_i = '0;
   logic [7:0] live_wreg_i = '0;
   logic [3:0] live_bank_i = '0;
   logic       irq_vec_i = 1'b0;
   logic       call_i = 1'b0;
   logic       call_fast_i = 1'b0;
   logic       ret_i = 1'b0;
   logic       reti_i = 1'b0;
   logic       ret_fast_i = 1'b0;
   logic [7:0] rst_stat_o;
   logic [7:0] rst_wreg_o;
   logic [3:0] rst_bank_o;
   logic       rst_valid_o;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 0;
   string req = "R1";

   // behavioural model state
   int m_stat = 0;
   int m_wreg = 0;
   int m_bank = 0;

   always #4 clk = ~clk;

   ctx_shadow_unit uut (
      .clk(clk), .rst_n(rst_n),
      .live_stat_i(live_stat_i), .live_wreg_i(live_wreg_i), .live_bank_i(live_bank_i),
      .irq_vec_i(irq_vec_i), .call_i(call_i), .call_fast_i(call_fast_i),
      .ret_i(ret_i), .reti_i(reti_i), .ret_fast_i(ret_fast_i),
      .rst_stat_o(rst_stat_o), .rst_wreg_o(rst_wreg_o), .rst_bank_o(rst_bank_o),
      .rst_valid_o(rst_valid_o)
   );

   task automatic compare(int ev, int es, int ew, int eb);
      n_checks++;
      if (rst_valid_o !== ev[0] || rst_stat_o !== es[7:0] ||
          rst_wreg_o !== ew[7:0] || rst_bank_o !== eb[3:0]) begin
         n_fail++;
         $display("FAIL %s: got v=%0d s=%02h w=%02h b=%0h expected v=%0d s=%02h w=%02h b=%0h",
                  req, rst_valid_o, rst_stat_o, rst_wreg_o, rst_bank_o,
                  ev, es[7:0], ew[7:0], eb[3:0]);
      end
   endtask

   // Apply one cycle of stimulus at a falling edge; at the next falling edge
   // advance the model with the same stimulus and compare (registered restore).
   task automatic step(bit irq, bit call, bit callf, bit ret, bit reti, bit retf,
                       int s, int w, int b);
      int fr, sv, es, ew, eb;
      irq_vec_i = irq; call_i = call; call_fast_i = callf;
      ret_i = ret; reti_i = reti; ret_fast_i = retf;
      live_stat_i = s[7:0]; live_wreg_i = w[7:0]; live_bank_i = b[3:0];
      @(negedge clk);
      fr = ((ret || reti) && retf) ? 1 : 0;
      sv = (irq || (call && callf)) ? 1 : 0;
      es = fr ? m_stat : 0;
      ew = fr ? m_wreg : 0;
      eb = fr ? m_bank : 0;
      if (sv != 0) begin
         m_stat = s & 8'hff; m_wreg = w & 8'hff; m_bank = b & 4'hf;
      end
      compare(fr, es, ew, eb);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state, and a fast return before any save yields zeros
      req = "R1";
      repeat (3) @(negedge clk);
      compare(0, 0, 0, 0);
      rst_n = 1'b1;
      idle(2);
      step(0, 0, 0, 1, 0, 1, 8'h5a, 8'h33, 4'h6);
      idle(1);

      // R2: interrupt vector saves, fast interrupt return restores
      req = "R2";
      step(1, 0, 0, 0, 0, 0, 8'ha1, 8'hb2, 4'hc);
      step(0, 0, 0, 0, 0, 0, 8'h11, 8'h22, 4'h3);
      step(0, 0, 0, 0, 1, 1, 8'h44, 8'h55, 4'h6);
      idle(1);

      // R3: unqualified call does not save; fast call does
      req = "R3";
      step(0, 1, 0, 0, 0, 0, 8'h77, 8'h88, 4'h9);
      step(0, 0, 0, 1, 0, 1, 0, 0, 0);
      step(0, 1, 1, 0, 0, 0, 8'hc3, 8'h3c, 4'h5);
      step(0, 0, 0, 1, 0, 1, 8'hff, 8'hff, 4'hf);
      idle(1);

      // R5: returns without the fast flag do nothing
      req = "R5";
      step(0, 0, 0, 1, 0, 0, 8'h01, 8'h02, 4'h3);
      step(0, 0, 0, 0, 1, 0, 8'h04, 8'h05, 4'h6);
      step(0, 0, 1, 0, 0, 1, 8'h07, 8'h08, 4'h9);
      idle(1);
      step(0, 0, 0, 0, 1, 1, 0, 0, 0);
      idle(1);

      // R6: second save overwrites the first
      req = "R6";
      step(1, 0, 0, 0, 0, 0, 8'h10, 8'h20, 4'h1);
      step(1, 0, 0, 0, 0, 0, 8'he0, 8'hd0, 4'he);
      step(0, 0, 0, 0, 1, 1, 0, 0, 0);
      idle(1);

      // R7: save and fast return in one cycle: old out, new kept
      req = "R7";
      step(1, 0, 0, 0, 1, 1, 8'h96, 8'h69, 4'ha);
      step(0, 1, 1, 1, 0, 1, 8'h3e, 8'he3, 4'h7);
      step(0, 0, 0, 1, 0, 1, 0, 0, 0);
      idle(1);

      // R8: consecutive fast returns, and both return kinds at once
      req = "R8";
      step(0, 0, 0, 1, 0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 0, 0, 0);
      step(0, 0, 0, 1, 1, 1, 0, 0, 0);
      idle(2);

      // R4/R9 with randomized dense traffic
      req = "R4";
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom;
         step(r[0] & r[1], r[2], r[3], r[4], r[5] & r[6], r[7],
              $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 15));
      end
      req = "R9";
      idle(3);
      finish_run();
   end

endmodule